// File: doc/BRIEF.md
# Bus Wake-Up Pattern Detector

This block is active while a bus transceiver sits in its low-power standby state. It watches the digitized output of a low-power differential comparator: 1 means the bus is dominant and 0 means it is recessive. It looks for a wake request made of three phases in a fixed order: dominant, then recessive, then dominant. Each phase must last a minimum filter time before it counts. All three phases must complete inside a timeout window. When the pattern qualifies, the block raises a wake flag. From then on the receive-data output follows the bus, low for dominant. Until then the receive-data output stays high.

The bus level first passes through a two-flop synchronizer. A per-level run-length filter sits behind it. A run shorter than the filter time is treated as noise and leaves the sequence where it was. A parameter chooses between a long filter length and a short filter length. The timeout counter starts when the first dominant phase qualifies. If the window expires, the sequence returns to idle. When the standby input is deasserted, the detector and the flag clear.

Top module: `wake_pattern_det`

## Requirements
- R1: `wake_valid_o` rises only after a qualified dominant, then a qualified recessive, then a qualified dominant phase, in that order. It is first high FILT_CYC+2 cycles after the bus input starts the third phase, and still low one cycle earlier.
- R2: A phase counts once `bus_dom_i` (1 = dominant, 0 = recessive) has held that level for at least FILT_CYC consecutive cycles. A first dominant phase of FILT_CYC-1 cycles does not count.
- R3: An excursion shorter than FILT_CYC cycles neither advances the sequence nor returns it to idle.
- R4: FILT_CYC equals FILT_SHORT_CYC when SHORT_FILTER is 1 and FILT_LONG_CYC when it is 0.
- R5: The timeout count starts when the first dominant phase qualifies. If wake is not reached within TIMEOUT_CYC cycles, the sequence returns to idle. A later qualified dominant phase then counts as a new first phase.
- R6: While `wake_valid_o` is 0, `rxd_o` is 1. While it is 1, `rxd_o` is the inverse of `bus_dom_i` as it was two cycles earlier.
- R7: Once set, `wake_valid_o` stays high for as long as `standby_i` stays high, whatever the bus does.
- R8: With `standby_i` low, `wake_valid_o` is 0 in that same cycle, and the sequence is in idle after the next clock edge.
- R9: After reset, `wake_valid_o` is 0 and `rxd_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | High while the transceiver is in standby; low clears the detector |
| bus_dom_i | input | 1 | Low-power receiver output, 1 = dominant |
| wake_valid_o | output | 1 | Wake pattern qualified |
| rxd_o | output | 1 | Receive-data drive value, low for dominant once awake |

## Verification
The bus input needs two synchronizer cycles and then FILT_CYC cycles of constant level before a phase counts. The state update lands on the same edge, so the wake flag is due exactly FILT_CYC+2 cycles after the third phase begins. The bench queues an expectation for that cycle and one for the cycle before it. After wake, a bus change reaches `rxd_o` two cycles later, and the bench checks at both one and two cycles. Leaving standby drops the flag in the same cycle, and that check is due at delay zero. Every expectation carries its due cycle. The monitor compares on the falling edge of exactly that cycle, while stimulus changes just after the rising edge.

// File: rtl/wpd_pkg.sv
package wpd_pkg;
  typedef enum logic [1:0] {
    WPD_IDLE = 2'd0,
    WPD_DOM1 = 2'd1,
    WPD_REC  = 2'd2,
    WPD_WAKE = 2'd3
  } wpd_state_e;
endpackage

// File: rtl/wpd_sync.sv
module wpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/wpd_filter.sv
module wpd_filter #(
  parameter int FILT_CYC = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic raw_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic          lvl_q;
  logic [CW-1:0] run_q;
  logic          differs, upd;

  assign differs = (raw_i != lvl_q);
  assign upd     = en_i && differs && (run_q == CW'(FILT_CYC - 1));
  assign rise_o  = upd && raw_i;
  assign fall_o  = upd && !raw_i;

  // a run shorter than FILT_CYC only restarts the counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else if (!en_i) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else if (upd) begin
      lvl_q <= raw_i;
      run_q <= '0;
    end else if (differs) begin
      run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end
endmodule

// File: rtl/wpd_seq.sv
module wpd_seq
  import wpd_pkg::*;
#(
  parameter int TIMEOUT_CYC = 60,
  parameter int TMO_W       = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output wpd_state_e       state_o,
  output logic [TMO_W-1:0] tmo_o
);
  wpd_state_e       state_q, state_d;
  logic [TMO_W-1:0] tmo_q, tmo_d;
  logic             expired;

  assign expired = (tmo_q == TMO_W'(TIMEOUT_CYC - 1));

  always_comb begin
    state_d = state_q;
    tmo_d   = '0;
    if (!en_i) begin
      state_d = WPD_IDLE;
    end else begin
      unique case (state_q)
        WPD_IDLE: if (rise_i) state_d = WPD_DOM1;
        WPD_DOM1: begin
          if (expired)     state_d = WPD_IDLE;
          else begin
            tmo_d = tmo_q + 1'b1;
            if (fall_i) state_d = WPD_REC;
          end
        end
        WPD_REC: begin
          if (expired)     state_d = WPD_IDLE;
          else if (rise_i) state_d = WPD_WAKE;
          else             tmo_d = tmo_q + 1'b1;
        end
        default: state_d = WPD_WAKE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WPD_IDLE;
      tmo_q   <= '0;
    end else begin
      state_q <= state_d;
      tmo_q   <= tmo_d;
    end
  end

  assign state_o = state_q;
  assign tmo_o   = tmo_q;
endmodule

// File: rtl/wake_pattern_det.sv
module wake_pattern_det
  import wpd_pkg::*;
#(
  parameter bit SHORT_FILTER   = 1'b0,
  parameter int FILT_LONG_CYC  = 12,
  parameter int FILT_SHORT_CYC = 5,
  parameter int TIMEOUT_CYC    = 60,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic standby_i,
  input  logic bus_dom_i,
  output logic wake_valid_o,
  output logic rxd_o
);
  localparam int FILT_CYC = SHORT_FILTER ? FILT_SHORT_CYC : FILT_LONG_CYC;
  localparam int TMO_W    = $clog2(TIMEOUT_CYC + 1);

  logic             bus_s, ph_rise, ph_fall;
  wpd_state_e       seq_state;
  logic [TMO_W-1:0] tmo_cnt;

  wpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (bus_dom_i),
    .q_o   (bus_s)
  );

  wpd_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (standby_i),
    .raw_i (bus_s),
    .rise_o(ph_rise),
    .fall_o(ph_fall)
  );

  wpd_seq #(.TIMEOUT_CYC(TIMEOUT_CYC), .TMO_W(TMO_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (standby_i),
    .rise_i (ph_rise),
    .fall_i (ph_fall),
    .state_o(seq_state),
    .tmo_o  (tmo_cnt)
  );

  // gate with standby so leaving it drops the flag in the same cycle
  assign wake_valid_o = standby_i && (seq_state == WPD_WAKE);
  assign rxd_o        = wake_valid_o ? !bus_s : 1'b1;
endmodule

// File: rtl/wpd_checker.sv
module wpd_checker
  import wpd_pkg::*;
#(
  parameter int TIMEOUT_CYC = 60,
  parameter int TMO_W       = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             standby_i,
  input logic             bus_dom_i,
  input logic             wake_valid_o,
  input logic             rxd_o,
  input wpd_state_e       state_i,
  input logic [TMO_W-1:0] tmo_i
);
  a_r1_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_i == WPD_WAKE) |-> $past(state_i) == WPD_REC);

  a_r5_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == WPD_DOM1 || state_i == WPD_REC) |-> (32'(tmo_i) < TIMEOUT_CYC));

  a_r6_rxd_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wake_valid_o |-> rxd_o);

  a_r6_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_valid_o && $past(wake_valid_o, 2)) |-> (rxd_o == !$past(bus_dom_i, 2)));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_valid_o && standby_i) |=> (wake_valid_o || !standby_i));

  a_r8_flag_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !standby_i |-> !wake_valid_o);

  a_r8_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !standby_i |=> state_i == WPD_IDLE);
endmodule

bind wake_pattern_det wpd_checker #(.TIMEOUT_CYC(TIMEOUT_CYC), .TMO_W(TMO_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .standby_i   (standby_i),
  .bus_dom_i   (bus_dom_i),
  .wake_valid_o(wake_valid_o),
  .rxd_o       (rxd_o),
  .state_i     (seq_state),
  .tmo_i       (tmo_cnt)
);

// File: tb/sim_wake_pattern_det.sv
module sim_wake_pattern_det;
  localparam int F = 12;
  localparam int S = 5;
  localparam int T = 60;
  localparam int L = F + 2;
  localparam int LS = S + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic standby = 1'b1;
  logic bus = 1'b0;
  logic w0, r0, w1, r1;
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  typedef struct {
    int    due;
    int    sel;
    bit    wake;
    bit    rxd;
    string tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wake_pattern_det #(.SHORT_FILTER(1'b0), .FILT_LONG_CYC(F), .FILT_SHORT_CYC(S),
                     .TIMEOUT_CYC(T)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .standby_i(standby), .bus_dom_i(bus),
    .wake_valid_o(w0), .rxd_o(r0));

  wake_pattern_det #(.SHORT_FILTER(1'b1), .FILT_LONG_CYC(F), .FILT_SHORT_CYC(S),
                     .TIMEOUT_CYC(T)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .standby_i(standby), .bus_dom_i(bus),
    .wake_valid_o(w1), .rxd_o(r1));

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic phase(bit lvl, int n);
    bus = lvl;
    step(n);
  endtask

  task automatic expect_at(int dly, int sel, bit w, bit r, string tag);
    exp_t e;
    e.due = cyc + dly; e.sel = sel; e.wake = w; e.rxd = r; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic clear_det();
    standby = 1'b0;
    bus = 1'b0;
    step(3);
    standby = 1'b1;
    step(2);
  endtask

  // monitor: compare on the falling edge of each item's due cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      bit aw, ar;
      e = q.pop_front();
      aw = (e.sel == 1) ? w1 : w0;
      ar = (e.sel == 1) ? r1 : r0;
      checks++;
      if (aw !== e.wake || ar !== e.rxd) begin
        errors++;
        $display("FAIL %s: wake=%0b rxd=%0b expected wake=%0b rxd=%0b",
                 e.tag, aw, ar, e.wake, e.rxd);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    // R9 reset state
    expect_at(0, 0, 1'b0, 1'b1, "R9 reset u0");
    expect_at(0, 1, 1'b0, 1'b1, "R9 reset u1");
    phase(1'b0, 20);

    // R1/R2 exact-length phases; R6 follow
    phase(1'b1, F);
    phase(1'b0, F);
    expect_at(L - 1, 0, 1'b0, 1'b1, "R1 not yet");
    expect_at(L, 0, 1'b1, 1'b0, "R1 wake due");
    phase(1'b1, F + 6);
    expect_at(1, 0, 1'b1, 1'b0, "R6 one cycle");
    expect_at(2, 0, 1'b1, 1'b1, "R6 recessive");
    phase(1'b0, 5);
    expect_at(2, 0, 1'b1, 1'b0, "R6 dominant");
    phase(1'b1, 5);
    // R7 hold through long bus idle
    phase(1'b0, 100);
    expect_at(0, 0, 1'b1, 1'b1, "R7 holds");
    step(1);
    // R8 leave standby
    standby = 1'b0;
    expect_at(0, 0, 1'b0, 1'b1, "R8 exit same cycle");
    step(1);
    standby = 1'b1;
    expect_at(3, 0, 1'b0, 1'b1, "R8 cleared");
    step(5);

    // R2 first phase one cycle short
    clear_det();
    phase(1'b1, F - 1);
    phase(1'b0, F);
    expect_at(L, 0, 1'b0, 1'b1, "R2 short phase");
    phase(1'b1, F + 4);

    // R3 glitch in recessive phase
    clear_det();
    phase(1'b1, F);
    phase(1'b0, 5);
    phase(1'b1, 3);
    phase(1'b0, F + 2);
    expect_at(L, 0, 1'b1, 1'b0, "R3 glitch ignored");
    phase(1'b1, F + 4);

    // R5 timeout then restart
    clear_det();
    phase(1'b1, F);
    phase(1'b0, T + 10);
    expect_at(L, 0, 1'b0, 1'b1, "R5 timeout");
    phase(1'b1, F + 2);
    phase(1'b0, F);
    expect_at(L, 0, 1'b1, 1'b0, "R5 restart");
    phase(1'b1, F + 4);

    // R4 short filter variant
    clear_det();
    phase(1'b1, S);
    phase(1'b0, S);
    expect_at(LS - 1, 1, 1'b0, 1'b1, "R4 short not yet");
    expect_at(LS, 1, 1'b1, 1'b0, "R4 short wake");
    expect_at(LS, 0, 1'b0, 1'b1, "R4 long idle");
    phase(1'b1, F + 4);
    expect_at(0, 0, 1'b0, 1'b1, "R4 long still idle");
    step(3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule